// File: doc/BRIEF.md
# Command Register with Argument Collector

This block sits behind a host register interface and turns a command code plus a stream of argument words into one dispatch event. The host writes a command code to the command register and then writes argument words, one at a time, to the command data register. Each command has a fixed argument length in 32-bit words. When the last required word arrives, the block raises a one-cycle dispatch strobe. The strobe carries the command code and the whole collected argument buffer. A command with no arguments dispatches in the same cycle as its command write.

An external handler returns a status word in the dispatch cycle. The block stores that word in a host-readable status register. Some commands always fail, and for those the block writes FAILED itself instead of the handler's word. Between a command write and its dispatch, the status reads "not enough data".

An unknown code is replaced by a sentinel command (code 0). The sentinel needs no arguments and always fails. After every dispatch the block returns to the sentinel, so argument words written with no command open are dropped.

Top module: `cmd_arg_collector`

## Requirements
- R1: After reset the status reads SUCCEEDED (0x00000000), no dispatch is raised, and the sentinel is current, so a data write right after reset causes no dispatch and leaves the status at 0.
- R2: A command value is valid only if it is greater than 0 and less than 10, judged on all 32 bits. Any other value (0, 10 or above, or high bits set) selects the sentinel code 0. The sentinel dispatches at once with dispatch code 0 and stores FAILED (0xFFFFFFFF).
- R3: A write of a command that needs arguments clears the argument count. From the next cycle the status reads NOT_ENOUGH_DATA (0xFFFFFFFE) until that command dispatches.
- R4: The zero-length commands are issue (2), unplug (3), bus reset (6) and adapter reset (8). Each raises the dispatch strobe in the cycle of its command write, and the result is in the status register from the next cycle.
- R5: The argument counts are config (1) = 6 words, setup rings (4) = 12, reset device (5) = 3, setup message ring (7) = 4 and abort (9) = 4. Dispatch is raised in the cycle the last word is written. Argument word i, counted in write order from 0, is dispArgs[32*i+31:32*i], and the word being written in the dispatch cycle is included.
- R6: Codes 0, 1, 2 and 3 always store FAILED. Codes 4, 5, 6, 8 and 9 store the handlerStatus value present in the dispatch cycle.
- R7: Setup message ring (7) stores FAILED when msgEnable is 0 in the dispatch cycle. Otherwise it stores its argument word count, 4.
- R8: After a dispatch the sentinel is current with a count of 0. Later data writes raise no dispatch and leave the status unchanged until the next command write.
- R9: A command write while a command is collecting abandons the old command and restarts collection. If a command write and a data write come in the same cycle, the command write wins and the data word is dropped.
- R10: The argument buffer holds 12 words, the largest argument count. No write is stored at or beyond that capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Write strobe of the command register |
| cmdWrData | input | 32 | Command code written |
| dataWrEn | input | 1 | Write strobe of the command data register |
| dataWrData | input | 32 | Argument word written |
| msgEnable | input | 1 | Message support is enabled |
| handlerStatus | input | 32 | Status returned by the handler in the dispatch cycle |
| statusOut | output | 32 | Command status register |
| dispValid | output | 1 | One-cycle dispatch strobe |
| dispCode | output | 4 | Command code being dispatched |
| dispArgs | output | 384 | Collected argument words, word 0 in the low bits |

## Verification
The dispatch strobe, the code and the argument buffer are combinational from the write strobes, so they are due in the same cycle as the write. The bench samples them 1 ns after it drives its inputs at the falling edge. The status register is due one rising edge later, and the bench reads it 1 ns after that edge, before it drives the next operation. A reference model in the bench computes the expected strobe, code, arguments and status for every operation, in both the directed cases and a seeded random mix of command writes, data writes and combined writes.

// File: rtl/cac_pkg.sv
`timescale 1ns/1ps
package cac_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [3:0] {
    CMD_NONE    = 4'd0,
    CMD_CONFIG  = 4'd1,
    CMD_ISSUE   = 4'd2,
    CMD_UNPLUG  = 4'd3,
    CMD_RINGS   = 4'd4,
    CMD_DEVRST  = 4'd5,
    CMD_BUSRST  = 4'd6,
    CMD_MSGRING = 4'd7,
    CMD_ADPRST  = 4'd8,
    CMD_ABORT   = 4'd9,
    CMD_LAST    = 4'd10
  } cmd_e;

  localparam logic [WORD_W-1:0] ST_OK   = 32'h0000_0000;
  localparam logic [WORD_W-1:0] ST_FAIL = 32'hFFFF_FFFF;
  localparam logic [WORD_W-1:0] ST_WAIT = 32'hFFFF_FFFE;

  // strobes from control to the argument datapath
  typedef struct packed {
    logic store;
    logic dispatch;
  } ctrl_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cac_argbuf.sv
`timescale 1ns/1ps
module cac_argbuf
  import cac_pkg::*;
#(
  parameter int DEPTH = 12,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctrl_t                   strobe,
  input  logic [IDX_W-1:0]        storeIdx,
  input  logic [WORD_W-1:0]       wrWord,
  output logic [DEPTH*WORD_W-1:0] argsFlat
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [WORD_W-1:0] wordQ;
    logic hit;
    assign hit = strobe.store && (storeIdx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) wordQ <= '0;
      else if (hit) wordQ <= wrWord;
    end
    // the word arriving in the dispatch cycle is already visible
    assign argsFlat[i*WORD_W +: WORD_W] = hit ? wrWord : wordQ;
  end

  // R10: stores never address past the buffer
  assert_store_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.store |-> (32'(storeIdx) < DEPTH));
endmodule

// File: rtl/cac_control.sv
`timescale 1ns/1ps
module cac_control
  import cac_pkg::*;
#(
  parameter int CONFIG_WORDS  = 6,
  parameter int RINGS_WORDS   = 12,
  parameter int DEVRST_WORDS  = 3,
  parameter int MSGRING_WORDS = 4,
  parameter int ABORT_WORDS   = 4,
  localparam int MAX_WORDS = maxOf(maxOf(maxOf(CONFIG_WORDS, RINGS_WORDS),
                              maxOf(DEVRST_WORDS, MSGRING_WORDS)), ABORT_WORDS),
  localparam int CNT_W = $clog2(MAX_WORDS + 1),
  localparam int IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdWrEn,
  input  logic [WORD_W-1:0] cmdWrData,
  input  logic              dataWrEn,
  input  logic              msgEnable,
  input  logic [WORD_W-1:0] handlerStatus,
  output ctrl_t             strobe,
  output logic [IDX_W-1:0]  storeIdx,
  output cmd_e              dispCode,
  output logic [WORD_W-1:0] statusOut
);
  cmd_e              curCmd, curNext, effCode;
  logic [CNT_W-1:0]  cnt, cntNext;
  logic [WORD_W-1:0] statNext;
  logic              codeOk;

  function automatic int unsigned needOf(input cmd_e c);
    case (c)
      CMD_CONFIG:  return CONFIG_WORDS;
      CMD_RINGS:   return RINGS_WORDS;
      CMD_DEVRST:  return DEVRST_WORDS;
      CMD_MSGRING: return MSGRING_WORDS;
      CMD_ABORT:   return ABORT_WORDS;
      default:     return 0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] resultOf(input cmd_e c, input logic msgOn,
                                                 input logic [WORD_W-1:0] hs);
    case (c)
      CMD_NONE, CMD_CONFIG, CMD_ISSUE, CMD_UNPLUG: return ST_FAIL;
      CMD_MSGRING: return msgOn ? WORD_W'(MSGRING_WORDS) : ST_FAIL;
      default:     return hs;
    endcase
  endfunction

  assign codeOk  = (cmdWrData != '0) && (cmdWrData < WORD_W'(CMD_LAST));
  assign effCode = codeOk ? cmd_e'(cmdWrData[3:0]) : CMD_NONE;

  always_comb begin
    strobe   = '0;
    curNext  = curCmd;
    cntNext  = cnt;
    statNext = statusOut;
    dispCode = curCmd;
    storeIdx = IDX_W'(cnt);
    if (cmdWrEn) begin
      dispCode = effCode;
      curNext  = effCode;
      cntNext  = '0;
      statNext = ST_WAIT;
      if (needOf(effCode) == 0) begin
        strobe.dispatch = 1'b1;
        statNext = resultOf(effCode, msgEnable, handlerStatus);
        curNext  = CMD_NONE;
      end
    end else if (dataWrEn && (curCmd != CMD_NONE) && (32'(cnt) < MAX_WORDS)) begin
      strobe.store = 1'b1;
      if ((32'(cnt) + 32'd1) >= needOf(curCmd)) begin
        strobe.dispatch = 1'b1;
        statNext = resultOf(curCmd, msgEnable, handlerStatus);
        curNext  = CMD_NONE;
        cntNext  = '0;
      end else begin
        cntNext = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curCmd    <= CMD_NONE;
      cnt       <= '0;
      statusOut <= ST_OK;
    end else begin
      curCmd    <= curNext;
      cnt       <= cntNext;
      statusOut <= statNext;
    end
  end

  assert_wait_after_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWrEn && !strobe.dispatch) |=> (statusOut == ST_WAIT));
  assert_sentinel_fails_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.dispatch && dispCode == CMD_NONE) |=> (statusOut == ST_FAIL));
  assert_idle_after_dispatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.dispatch |=> (curCmd == CMD_NONE && cnt == '0));
  assert_idle_data_no_dispatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dataWrEn && !cmdWrEn && curCmd == CMD_NONE) |-> !strobe.dispatch);
  assert_idle_data_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dataWrEn && !cmdWrEn && curCmd == CMD_NONE) |=> $stable(statusOut));
  assert_msg_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.dispatch && dispCode == CMD_MSGRING && !msgEnable) |=> (statusOut == ST_FAIL));
  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt) < MAX_WORDS));
  assert_dispatch_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.dispatch |-> (cmdWrEn || dataWrEn));
endmodule

// File: rtl/cmd_arg_collector.sv
`timescale 1ns/1ps
module cmd_arg_collector
  import cac_pkg::*;
#(
  parameter int CONFIG_WORDS  = 6,
  parameter int RINGS_WORDS   = 12,
  parameter int DEVRST_WORDS  = 3,
  parameter int MSGRING_WORDS = 4,
  parameter int ABORT_WORDS   = 4,
  localparam int MAX_WORDS = maxOf(maxOf(maxOf(CONFIG_WORDS, RINGS_WORDS),
                              maxOf(DEVRST_WORDS, MSGRING_WORDS)), ABORT_WORDS),
  localparam int IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmdWrEn,
  input  logic [WORD_W-1:0]           cmdWrData,
  input  logic                        dataWrEn,
  input  logic [WORD_W-1:0]           dataWrData,
  input  logic                        msgEnable,
  input  logic [WORD_W-1:0]           handlerStatus,
  output logic [WORD_W-1:0]           statusOut,
  output logic                        dispValid,
  output logic [3:0]                  dispCode,
  output logic [MAX_WORDS*WORD_W-1:0] dispArgs
);
  ctrl_t            strobe;
  logic [IDX_W-1:0] storeIdx;
  cmd_e             codeSel;

  cac_control #(
    .CONFIG_WORDS (CONFIG_WORDS),
    .RINGS_WORDS  (RINGS_WORDS),
    .DEVRST_WORDS (DEVRST_WORDS),
    .MSGRING_WORDS(MSGRING_WORDS),
    .ABORT_WORDS  (ABORT_WORDS)
  ) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmdWrEn      (cmdWrEn),
    .cmdWrData    (cmdWrData),
    .dataWrEn     (dataWrEn),
    .msgEnable    (msgEnable),
    .handlerStatus(handlerStatus),
    .strobe       (strobe),
    .storeIdx     (storeIdx),
    .dispCode     (codeSel),
    .statusOut    (statusOut)
  );

  cac_argbuf #(.DEPTH(MAX_WORDS)) buf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .storeIdx(storeIdx),
    .wrWord  (dataWrData),
    .argsFlat(dispArgs)
  );

  assign dispValid = strobe.dispatch;
  assign dispCode  = codeSel;
endmodule

// File: tb/cmd_arg_collector_tb_top.sv
`timescale 1ns/1ps
module cmd_arg_collector_tb_top;
  localparam int NW = 12;
  localparam int unsigned FAILV = 32'hFFFF_FFFF;
  localparam int unsigned WAITV = 32'hFFFF_FFFE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdWrEn = 1'b0, dataWrEn = 1'b0, msgEnable = 1'b1;
  logic [31:0] cmdWrData = '0, dataWrData = '0, handlerStatus = '0;
  logic [31:0] statusOut;
  logic dispValid;
  logic [3:0] dispCode;
  logic [NW*32-1:0] dispArgs;

  int checks = 0, fails = 0;
  int mCur = 0, mCnt = 0;
  int unsigned mStatus = 0;
  int unsigned mWords [NW];

  always #2.5 clk = ~clk;

  cmd_arg_collector dut_i (
    .clk(clk), .rst_n(rst_n), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .dataWrEn(dataWrEn), .dataWrData(dataWrData), .msgEnable(msgEnable),
    .handlerStatus(handlerStatus), .statusOut(statusOut), .dispValid(dispValid),
    .dispCode(dispCode), .dispArgs(dispArgs));

  function automatic int needOf(input int c);
    case (c)
      1: return 6;
      4: return 12;
      5: return 3;
      7: return 4;
      9: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned resOf(input int c, input bit me, input int unsigned hs);
    if (c <= 3) return FAILV;
    if (c == 7) return me ? 32'd4 : FAILV;
    return hs;
  endfunction

  task automatic check(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic op(input bit ce, input int unsigned cv, input bit de, input int unsigned dv,
                    input int unsigned hs, input bit me, input string tag);
    bit expDisp = 0;
    int expCode = 0;
    int unsigned newStat = mStatus;
    @(negedge clk);
    cmdWrEn = ce; cmdWrData = cv; dataWrEn = de; dataWrData = dv;
    handlerStatus = hs; msgEnable = me;
    if (ce) begin
      int eff = (cv > 0 && cv < 10) ? int'(cv) : 0;
      mCur = eff; mCnt = 0; newStat = WAITV;
      if (needOf(eff) == 0) begin
        expDisp = 1; expCode = eff; newStat = resOf(eff, me, hs); mCur = 0;
      end
    end else if (de && mCur != 0 && mCnt < NW) begin
      mWords[mCnt] = dv; mCnt++;
      if (mCnt >= needOf(mCur)) begin
        expDisp = 1; expCode = mCur; newStat = resOf(mCur, me, hs); mCur = 0; mCnt = 0;
      end
    end
    #1;
    check(dispValid == expDisp, {tag, " dispValid"}, dispValid, expDisp);
    if (expDisp) begin
      check(int'(dispCode) == expCode, {tag, " dispCode"}, dispCode, expCode);
      for (int i = 0; i < needOf(expCode); i++)
        check(dispArgs[i*32 +: 32] == mWords[i], {tag, " arg word"}, dispArgs[i*32 +: 32], mWords[i]);
    end
    @(posedge clk); #1;
    check(statusOut == newStat, {tag, " status"}, statusOut, newStat);
    mStatus = newStat;
    cmdWrEn = 0; dataWrEn = 0;
  endtask

  task automatic runCmd(input int code, input int nData, input int unsigned hs, input bit me,
                        input string tag);
    op(1, code, 0, 0, hs, me, tag);
    for (int i = 0; i < nData; i++) op(0, 0, 1, $urandom, hs, me, tag);
  endtask

  initial begin
    #500000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(statusOut == 0, "R1 reset status", statusOut, 0);
    check(dispValid == 0, "R1 reset dispatch", dispValid, 0);
    op(0, 0, 1, 32'hDEAD_BEEF, 32'h55, 1, "R1");
    // R2 invalid codes
    op(1, 0, 0, 0, 32'h1, 1, "R2");
    op(1, 10, 0, 0, 32'h1, 1, "R2");
    op(1, 32'h8000_0004, 0, 0, 32'h1, 1, "R2");
    // R3 / R6 config collects six words then fails
    runCmd(1, 6, 32'h0, 1, "R3");
    // R4 zero-length commands
    runCmd(6, 0, 32'h1234, 1, "R4");
    runCmd(8, 0, 32'h0, 1, "R4");
    runCmd(2, 0, 32'h0, 1, "R6");
    runCmd(3, 0, 32'h77, 1, "R6");
    // R5 / R10 twelve-word command then extra data ignored
    runCmd(4, 12, 32'hA5A5_0001, 1, "R10");
    op(0, 0, 1, 32'h1111, 32'h9, 1, "R8");
    op(0, 0, 1, 32'h2222, 32'h9, 1, "R8");
    runCmd(5, 3, 32'h42, 1, "R5");
    runCmd(9, 4, 32'h0, 1, "R5");
    // R7 message ring
    runCmd(7, 4, 32'h0, 0, "R7");
    runCmd(7, 4, 32'h0, 1, "R7");
    // R9 restart and combined writes
    runCmd(5, 2, 32'h5, 1, "R9");
    runCmd(9, 4, 32'h6, 1, "R9");
    op(1, 5, 1, 32'hCAFE, 32'h7, 1, "R9");
    for (int i = 0; i < 3; i++) op(0, 0, 1, $urandom, 32'h7, 1, "R9");
    // random mix
    for (int n = 0; n < 600; n++) begin
      int sel = $urandom_range(0, 9);
      int unsigned cv = ($urandom_range(0, 7) == 0) ? $urandom : $urandom_range(0, 12);
      bit ce = (sel < 3) || (sel == 9);
      bit de = (sel >= 3);
      op(ce, cv, de, $urandom, $urandom, bit'($urandom_range(0, 1)), "R5 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule